// File: doc/BRIEF.md
# Six-Channel Peripheral DMA Controller

This block moves data between memory and peripheral FIFOs on behalf of up to six independent channels. Software programs each channel through a 32-bit register slave port. It sets the two addresses, the number of transfer units, a command word (address stepping, beat widths, unit size, interrupt enable) and a status/control word that arms the channel. A channel then waits for its peripheral request line. Each time the request is seen high at a unit boundary, the channel moves one unit of data over a single shared memory-master port.

Every unit is carried out as one or more segments. A segment reads beats at the source width into a 32-bit staging word and then drains it in beats at the destination width. Beat widths are capped at the unit size, so a 1-byte unit always moves single bytes. Addresses that step advance by their own side's beat width. A fixed address stays put, which suits a FIFO. The count register always shows the units still to move. At zero the channel flags completion and can raise its interrupt. A misaligned address stops the channel with an error before any beat is issued. When several channels are ready, a round-robin order picks one per unit.

Top module: `pdma_top`

## Requirements
- R1: After reset every channel register, the global control word and the interrupt summary read zero, irq is low and m_req is low.
- R2: A channel starts a unit only when its status bit 0 (enable) and bit 31 (armed) are set, its halt bit 2 is clear, its count is nonzero, global control bit 0 (enable) is set and global bit 3 (halt) is clear. Otherwise it issues no memory beat.
- R3: Width codes (command 15:14 source, 13:12 destination) are 0=4, 1=1 and 2=2 bytes. Unit codes (command 10:8) are 0=4, 1=1, 2=2, 3=16 and 4=32 bytes. Beat width is min(width, unit). A segment of max(source beat, destination beat) bytes is read and then written. Bytes pack little-endian with data right-aligned on the 32-bit bus, and m_size is 0/1/2 for 1/2/4 bytes.
- R4: Command bit 23 makes the source address and bit 22 the destination address advance by that side's beat width after each acknowledged beat. With the bit clear, the address stays unchanged.
- R5: The count register (channel offset 0x08) decrements by one per completed unit and reads back the live remaining units.
- R6: When the count reaches zero the channel sets status bits 3 (done) and 1 (count terminate) and starts no further unit.
- R7: Interrupt summary (0x304) bit i is set while channel i has done set and command bit 1 set. irq is the OR of the summary. Writing zero to a channel's enable and done bits clears its summary bit.
- R8: If the address of a beat is not aligned to its beat width, the beat is not issued. The channel sets status bits 4 (address error) and 2 (halt), global bit 2 is set, and the count is unchanged.
- R9: With several channels ready, units are granted in ascending cyclic channel order starting after the last granted channel (channel 0 first after reset).
- R10: A request that is high for one cycle while the engine is idle yields exactly one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_addr | input | 10 | Register byte address; channel n at n*0x20, global at 0x300 |
| s_we | input | 1 | Register write strobe |
| s_wdata | input | 32 | Register write data |
| s_rdata | output | 32 | Register read data for s_addr, combinational |
| dreq | input | 6 | Peripheral request, one per channel |
| m_req | output | 1 | Memory beat request, held until acknowledged |
| m_addr | output | 32 | Memory byte address |
| m_we | output | 1 | 1 for a write beat, 0 for a read beat |
| m_size | output | 2 | Beat size: 0=1, 1=2, 2=4 bytes |
| m_wdata | output | 32 | Write data, right-aligned |
| m_rdata | input | 32 | Read data, right-aligned, valid with m_ack |
| m_ack | input | 1 | Beat acknowledge |
| irq | output | 1 | Interrupt, OR of the summary bits |

## Verification
A wrong segment or beat counter shows as a wrong number of memory beats and misplaced bytes at the destination within the same unit. A stepping error shows in the address registers read back at the end of the transfer. A count or done-flag fault shows in the count register and in irq one cycle after the last write acknowledge. Arbitration faults show as a reordered sequence of read addresses on m_addr while two channels compete. Gating or alignment faults show as beats that appear on m_req when none are allowed.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  localparam logic [4:0] OFF_SRC = 5'h00;
  localparam logic [4:0] OFF_DST = 5'h04;
  localparam logic [4:0] OFF_CNT = 5'h08;
  localparam logic [4:0] OFF_RTY = 5'h0C;
  localparam logic [4:0] OFF_STC = 5'h10;
  localparam logic [4:0] OFF_CMD = 5'h14;

  typedef struct packed {
    logic       src_inc;
    logic       dst_inc;
    logic [1:0] sw;
    logic [1:0] dw;
    logic [2:0] unit;
    logic       tie;
  } cmd_t;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2} eng_st_t;

  // log2 of the unit size in bytes
  function automatic logic [2:0] unit_log(input logic [2:0] u);
    case (u)
      3'd1:    unit_log = 3'd0;
      3'd2:    unit_log = 3'd1;
      3'd3:    unit_log = 3'd4;
      3'd4:    unit_log = 3'd5;
      default: unit_log = 3'd2;
    endcase
  endfunction

  // log2 of the bus width in bytes
  function automatic logic [2:0] width_log(input logic [1:0] w);
    case (w)
      2'd1:    width_log = 3'd0;
      2'd2:    width_log = 3'd1;
      default: width_log = 3'd2;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] l);
    case (l)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    wr_off,
  input  logic [31:0]   wr_data,
  input  logic [4:0]    rd_off,
  input  logic          step_src,
  input  logic          step_dst,
  input  logic [2:0]    src_amt,
  input  logic [2:0]    dst_amt,
  input  logic          unit_done,
  input  logic          addr_err,
  output logic [31:0]   rd_data,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output cmd_t          cmd,
  output logic          ready,
  output logic          irq_bit
);

  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [7:0]    rty_q, rty_n;
  cmd_t          cmd_q, cmd_n;
  logic en_q, en_n, ct_q, ct_n, hlt_q, hlt_n, dn_q, dn_n, ae_q, ae_n, nd_q, nd_n;
  logic done_hit;

  always_comb begin
    src_n = src_q;
    dst_n = dst_q;
    cnt_n = cnt_q;
    rty_n = rty_q;
    cmd_n = cmd_q;
    en_n = en_q; ct_n = ct_q; hlt_n = hlt_q; dn_n = dn_q; ae_n = ae_q; nd_n = nd_q;
    done_hit = 1'b0;
    // engine updates first; a software write of the same register wins
    if (step_src && cmd_q.src_inc) src_n = src_q + AW'(src_amt);
    if (step_dst && cmd_q.dst_inc) dst_n = dst_q + AW'(dst_amt);
    if (unit_done && (cnt_q != '0)) begin
      cnt_n    = cnt_q - CW'(1);
      done_hit = (cnt_q == CW'(1));
    end
    if (wr_en) begin
      case (wr_off)
        OFF_SRC: src_n = wr_data[AW-1:0];
        OFF_DST: dst_n = wr_data[AW-1:0];
        OFF_CNT: cnt_n = wr_data[CW-1:0];
        OFF_RTY: rty_n = wr_data[7:0];
        OFF_STC: begin
          en_n = wr_data[0]; ct_n = wr_data[1]; hlt_n = wr_data[2];
          dn_n = wr_data[3]; ae_n = wr_data[4]; nd_n = wr_data[31];
        end
        OFF_CMD: begin
          cmd_n.src_inc = wr_data[23];
          cmd_n.dst_inc = wr_data[22];
          cmd_n.sw      = wr_data[15:14];
          cmd_n.dw      = wr_data[13:12];
          cmd_n.unit    = wr_data[10:8];
          cmd_n.tie     = wr_data[1];
        end
        default: ;
      endcase
    end
    // status flags raised by the engine win over the write
    if (done_hit) begin
      dn_n = 1'b1;
      ct_n = 1'b1;
    end
    if (addr_err) begin
      ae_n  = 1'b1;
      hlt_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; rty_q <= '0; cmd_q <= '0;
      en_q <= 1'b0; ct_q <= 1'b0; hlt_q <= 1'b0; dn_q <= 1'b0; ae_q <= 1'b0; nd_q <= 1'b0;
    end else begin
      src_q <= src_n; dst_q <= dst_n; cnt_q <= cnt_n; rty_q <= rty_n; cmd_q <= cmd_n;
      en_q <= en_n; ct_q <= ct_n; hlt_q <= hlt_n; dn_q <= dn_n; ae_q <= ae_n; nd_q <= nd_n;
    end
  end

  always_comb begin
    case (rd_off)
      OFF_SRC: rd_data = 32'(src_q);
      OFF_DST: rd_data = 32'(dst_q);
      OFF_CNT: rd_data = 32'(cnt_q);
      OFF_RTY: rd_data = 32'(rty_q);
      OFF_STC: rd_data = {nd_q, 26'd0, ae_q, dn_q, hlt_q, ct_q, en_q};
      OFF_CMD: rd_data = {8'd0, cmd_q.src_inc, cmd_q.dst_inc, 6'd0, cmd_q.sw, cmd_q.dw,
                          1'b0, cmd_q.unit, 6'd0, cmd_q.tie, 1'b0};
      default: rd_data = 32'd0;
    endcase
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign cmd      = cmd_q;
  assign ready    = en_q & nd_q & ~hlt_q & (cnt_q != '0);
  assign irq_bit  = dn_q & cmd_q.tie;

endmodule

// File: rtl/pdma_rr_arb.sv
module pdma_rr_arb #(
  parameter int N  = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ready,
  input  logic          take,
  output logic          vld,
  output logic [IW-1:0] idx
);

  logic [IW-1:0] last_q, last_n;

  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!vld && ready[c]) begin
        vld = 1'b1;
        idx = IW'(c);
      end
    end
    last_n = (take && vld) ? idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_n;
  end

endmodule

// File: rtl/pdma_mover.sv
module pdma_mover
  import pdma_pkg::*;
#(
  parameter int N  = 6,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant_vld,
  input  logic [IW-1:0] grant_idx,
  input  logic [1:0]    g_sw,
  input  logic [1:0]    g_dw,
  input  logic [2:0]    g_unit,
  input  logic [AW-1:0] cur_src,
  input  logic [AW-1:0] cur_dst,
  output logic [IW-1:0] cur,
  output logic          busy,
  output logic          start,
  output logic          step_src,
  output logic          step_dst,
  output logic [2:0]    src_amt,
  output logic [2:0]    dst_amt,
  output logic          unit_done,
  output logic          addr_err,
  output logic          m_req,
  output logic [AW-1:0] m_addr,
  output logic          m_we,
  output logic [1:0]    m_size,
  output logic [31:0]   m_wdata,
  input  logic [31:0]   m_rdata,
  input  logic          m_ack
);

  eng_st_t       st_q, st_n;
  logic [IW-1:0] cur_q, cur_n;
  logic [1:0]    wsl_q, wsl_n, wdl_q, wdl_n;
  logic [4:0]    seg_q, seg_n;
  logic [1:0]    rdc_q, rdc_n, wrc_q, wrc_n, rdl_q, rdl_n, wrl_q, wrl_n;
  logic [1:0]    roff_q, roff_n, woff_q, woff_n;
  logic [31:0]   stg_q, stg_n;

  logic [2:0] ul, gws, gwd, gsl;
  logic       aligned, active;

  always_comb begin
    ul  = unit_log(g_unit);
    gws = (width_log(g_sw) < ul) ? width_log(g_sw) : ul;
    gwd = (width_log(g_dw) < ul) ? width_log(g_dw) : ul;
    gsl = (gws > gwd) ? gws : gwd;
  end

  assign active = (st_q != S_IDLE);
  assign m_we   = (st_q == S_WR);
  assign m_addr = m_we ? cur_dst : cur_src;
  assign m_size = m_we ? wdl_q : wsl_q;

  always_comb begin
    case (m_size)
      2'd0:    aligned = 1'b1;
      2'd1:    aligned = ~m_addr[0];
      default: aligned = (m_addr[1:0] == 2'b00);
    endcase
  end

  assign m_req    = active & aligned;
  assign addr_err = active & ~aligned;
  assign m_wdata  = (stg_q >> {woff_q, 3'b000}) & lane_mask(wdl_q);
  assign src_amt  = 3'd1 << wsl_q;
  assign dst_amt  = 3'd1 << wdl_q;

  always_comb begin
    st_n = st_q; cur_n = cur_q; wsl_n = wsl_q; wdl_n = wdl_q; seg_n = seg_q;
    rdc_n = rdc_q; wrc_n = wrc_q; rdl_n = rdl_q; wrl_n = wrl_q;
    roff_n = roff_q; woff_n = woff_q; stg_n = stg_q;
    start = 1'b0; unit_done = 1'b0; step_src = 1'b0; step_dst = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (grant_vld) begin
          start  = 1'b1;
          cur_n  = grant_idx;
          wsl_n  = gws[1:0];
          wdl_n  = gwd[1:0];
          seg_n  = 5'((6'd1 << (ul - gsl)) - 6'd1);
          rdl_n  = 2'((3'd1 << (gsl - gws)) - 3'd1);
          wrl_n  = 2'((3'd1 << (gsl - gwd)) - 3'd1);
          rdc_n  = 2'((3'd1 << (gsl - gws)) - 3'd1);
          wrc_n  = 2'((3'd1 << (gsl - gwd)) - 3'd1);
          roff_n = 2'd0;
          woff_n = 2'd0;
          stg_n  = 32'd0;
          st_n   = S_RD;
        end
      end
      S_RD: begin
        if (!aligned) begin
          st_n = S_IDLE;
        end else if (m_ack) begin
          step_src = 1'b1;
          stg_n = stg_q | ((m_rdata & lane_mask(wsl_q)) << {roff_q, 3'b000});
          if (rdc_q == 2'd0) begin
            st_n = S_WR;
          end else begin
            rdc_n  = rdc_q - 2'd1;
            roff_n = roff_q + 2'(3'd1 << wsl_q);
          end
        end
      end
      S_WR: begin
        if (!aligned) begin
          st_n = S_IDLE;
        end else if (m_ack) begin
          step_dst = 1'b1;
          if (wrc_q != 2'd0) begin
            wrc_n  = wrc_q - 2'd1;
            woff_n = woff_q + 2'(3'd1 << wdl_q);
          end else if (seg_q == 5'd0) begin
            unit_done = 1'b1;
            st_n      = S_IDLE;
          end else begin
            seg_n  = seg_q - 5'd1;
            rdc_n  = rdl_q;
            wrc_n  = wrl_q;
            roff_n = 2'd0;
            woff_n = 2'd0;
            stg_n  = 32'd0;
            st_n   = S_RD;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_q <= '0; wsl_q <= '0; wdl_q <= '0; seg_q <= '0;
      rdc_q <= '0; wrc_q <= '0; rdl_q <= '0; wrl_q <= '0;
      roff_q <= '0; woff_q <= '0; stg_q <= '0;
    end else begin
      st_q <= st_n; cur_q <= cur_n; wsl_q <= wsl_n; wdl_q <= wdl_n; seg_q <= seg_n;
      rdc_q <= rdc_n; wrc_q <= wrc_n; rdl_q <= rdl_n; wrl_q <= wrl_n;
      roff_q <= roff_n; woff_q <= woff_n; stg_q <= stg_n;
    end
  end

  assign cur  = cur_q;
  assign busy = active;

endmodule

// File: rtl/pdma_top.sv
module pdma_top
  import pdma_pkg::*;
#(
  parameter int N_CH = 6,
  parameter int AW   = 32,
  parameter int CW   = 24,
  parameter int RAW  = 10,
  localparam int IW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RAW-1:0]  s_addr,
  input  logic            s_we,
  input  logic [31:0]     s_wdata,
  output logic [31:0]     s_rdata,
  input  logic [N_CH-1:0] dreq,
  output logic            m_req,
  output logic [AW-1:0]   m_addr,
  output logic            m_we,
  output logic [1:0]      m_size,
  output logic [31:0]     m_wdata,
  input  logic [31:0]     m_rdata,
  input  logic            m_ack,
  output logic            irq
);

  localparam logic [RAW-1:0] A_GCTRL = RAW'(10'h300);
  localparam logic [RAW-1:0] A_GIRQ  = RAW'(10'h304);

  logic gen_q, gen_n, gae_q, gae_n, ghalt_q, ghalt_n;

  logic [31:0]   ch_rd   [N_CH];
  logic [AW-1:0] ch_src  [N_CH];
  logic [AW-1:0] ch_dst  [N_CH];
  cmd_t          ch_cmd  [N_CH];
  logic [N_CH-1:0] ch_ready, ch_irq, arb_ready;

  logic          grant_vld, eng_busy, eng_start, eng_ssrc, eng_sdst, eng_udone, eng_aerr;
  logic [IW-1:0] grant_idx, eng_cur;
  logic [2:0]    eng_samt, eng_damt;

  logic [RAW-6:0] ch_sel;
  assign ch_sel = s_addr[RAW-1:5];

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic here;
      assign here = (eng_cur == IW'(i));
      pdma_chan #(.AW(AW), .CW(CW)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (s_we && (ch_sel == (RAW-5)'(i))),
        .wr_off    (s_addr[4:0]),
        .wr_data   (s_wdata),
        .rd_off    (s_addr[4:0]),
        .step_src  (eng_ssrc & here),
        .step_dst  (eng_sdst & here),
        .src_amt   (eng_samt),
        .dst_amt   (eng_damt),
        .unit_done (eng_udone & here),
        .addr_err  (eng_aerr & here),
        .rd_data   (ch_rd[i]),
        .src_addr  (ch_src[i]),
        .dst_addr  (ch_dst[i]),
        .cmd       (ch_cmd[i]),
        .ready     (ch_ready[i]),
        .irq_bit   (ch_irq[i])
      );
      assign arb_ready[i] = ch_ready[i] & dreq[i] & gen_q & ~ghalt_q;
    end
  endgenerate

  pdma_rr_arb #(.N(N_CH)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (arb_ready),
    .take  (eng_start),
    .vld   (grant_vld),
    .idx   (grant_idx)
  );

  pdma_mover #(.N(N_CH), .AW(AW)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx),
    .g_sw      (ch_cmd[grant_idx].sw),
    .g_dw      (ch_cmd[grant_idx].dw),
    .g_unit    (ch_cmd[grant_idx].unit),
    .cur_src   (ch_src[eng_cur]),
    .cur_dst   (ch_dst[eng_cur]),
    .cur       (eng_cur),
    .busy      (eng_busy),
    .start     (eng_start),
    .step_src  (eng_ssrc),
    .step_dst  (eng_sdst),
    .src_amt   (eng_samt),
    .dst_amt   (eng_damt),
    .unit_done (eng_udone),
    .addr_err  (eng_aerr),
    .m_req     (m_req),
    .m_addr    (m_addr),
    .m_we      (m_we),
    .m_size    (m_size),
    .m_wdata   (m_wdata),
    .m_rdata   (m_rdata),
    .m_ack     (m_ack)
  );

  always_comb begin
    gen_n = gen_q; gae_n = gae_q; ghalt_n = ghalt_q;
    if (s_we && (s_addr == A_GCTRL)) begin
      gen_n   = s_wdata[0];
      gae_n   = s_wdata[2];
      ghalt_n = s_wdata[3];
    end
    if (eng_aerr) gae_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= 1'b0; gae_q <= 1'b0; ghalt_q <= 1'b0;
    end else begin
      gen_q <= gen_n; gae_q <= gae_n; ghalt_q <= ghalt_n;
    end
  end

  always_comb begin
    if (int'(ch_sel) < N_CH)      s_rdata = ch_rd[ch_sel[IW-1:0]];
    else if (s_addr == A_GCTRL)   s_rdata = {28'd0, ghalt_q, gae_q, 1'b0, gen_q};
    else if (s_addr == A_GIRQ)    s_rdata = 32'(ch_irq);
    else                          s_rdata = 32'd0;
  end

  assign irq = |ch_irq;

endmodule

// File: rtl/pdma_checker.sv
module pdma_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_req,
  input logic          m_ack,
  input logic [AW-1:0] m_addr,
  input logic          m_we,
  input logic [1:0]    m_size,
  input logic          busy,
  input logic          gen,
  input logic          ghalt
);

  // R8: no beat is ever presented at a misaligned address
  a_r8_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> ((m_size == 2'd0) || (m_size == 2'd1 && !m_addr[0]) ||
               (m_size == 2'd2 && m_addr[1:0] == 2'b00)));

  // R3: beat size is one of the three legal codes
  a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> (m_size != 2'd3));

  // R3: a pending beat holds its request, address, direction and size
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_size)));

  // R2: an idle engine with global enable off or halt on starts no beat
  a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!gen || ghalt)) |=> !m_req);

endmodule

bind pdma_top pdma_checker #(.AW(AW)) u_pdma_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .m_req  (m_req),
  .m_ack  (m_ack),
  .m_addr (m_addr),
  .m_we   (m_we),
  .m_size (m_size),
  .busy   (eng_busy),
  .gen    (gen_q),
  .ghalt  (ghalt_q)
);

// File: tb/tb_pdma_top.sv
module tb_pdma_top;

  localparam int CLK_P = 10;
  localparam int MEMB  = 1024;

  localparam logic [31:0] ST_EN  = 32'h0000_0001;
  localparam logic [31:0] ST_CT  = 32'h0000_0002;
  localparam logic [31:0] ST_HLT = 32'h0000_0004;
  localparam logic [31:0] ST_DN  = 32'h0000_0008;
  localparam logic [31:0] ST_AE  = 32'h0000_0010;
  localparam logic [31:0] ST_ND  = 32'h8000_0000;

  logic        clk, rst_n;
  logic [9:0]  s_addr;
  logic        s_we;
  logic [31:0] s_wdata, s_rdata;
  logic [5:0]  dreq;
  logic        m_req, m_we, m_ack, irq;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;

  logic [7:0]  mem [MEMB];
  int          checks, errors, beats;
  logic        log_en;
  logic [31:0] rlog [16];
  int          nlog;
  logic        finished;

  pdma_top dut (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .dreq(dreq), .m_req(m_req), .m_addr(m_addr), .m_we(m_we),
    .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // memory model: acknowledge one cycle after a request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack   <= 1'b0;
      m_rdata <= 32'd0;
    end else if (m_req && !m_ack) begin
      logic [31:0] rd;
      m_ack <= 1'b1;
      rd = 32'd0;
      for (int b = 0; b < 4; b++) begin
        if (b < (1 << m_size)) begin
          if (m_we) mem[(int'(m_addr) + b) % MEMB] <= m_wdata[8*b +: 8];
          else      rd[8*b +: 8] = mem[(int'(m_addr) + b) % MEMB];
        end
      end
      if (!m_we) m_rdata <= rd;
    end else begin
      m_ack <= 1'b0;
    end
  end

  // beat monitor
  always @(posedge clk) begin
    if (m_req && m_ack) begin
      beats <= beats + 1;
      if (log_en && !m_we && nlog < 16) begin
        rlog[nlog] <= m_addr;
        nlog <= nlog + 1;
      end
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'(a ^ 8'h5A);
  endfunction

  function automatic logic [9:0] ca(input int ch, input int off);
    return 10'(ch * 32 + off);
  endfunction

  function automatic logic [31:0] mkcmd(input bit si, input bit di, input int sw,
                                        input int dw, input int un, input bit tie);
    return (32'(si) << 23) | (32'(di) << 22) | (32'(sw) << 14) | (32'(dw) << 12) |
           (32'(un) << 8) | (32'(tie) << 1);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    s_addr = a; s_wdata = d; s_we = 1'b1;
    @(negedge clk);
    s_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    s_addr = a;
    #1 d = s_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int ch, input int src, input int dst, input int cnt,
                       input logic [31:0] cmd);
    wr(ca(ch, 'h10), 32'd0);
    wr(ca(ch, 'h00), 32'(src));
    wr(ca(ch, 'h04), 32'(dst));
    wr(ca(ch, 'h08), 32'(cnt));
    wr(ca(ch, 'h14), cmd);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(ca(0, 'h10), v); chk("R1", "ch0 status", v, 0);
    rd(ca(5, 'h14), v); chk("R1", "ch5 command", v, 0);
    rd(ca(3, 'h08), v); chk("R1", "ch3 count", v, 0);
    rd(10'h300, v);     chk("R1", "global ctrl", v, 0);
    rd(10'h304, v);     chk("R1", "irq summary", v, 0);
    chk("R1", "irq/m_req", {30'd0, irq, m_req}, 0);
  endtask

  // word copy, both incrementing, interrupt enabled
  task automatic t_copy_words;
    logic [31:0] v;
    int bad;
    setup(0, 'h010, 'h200, 4, mkcmd(1, 1, 0, 0, 0, 1));
    wr(ca(0, 'h10), ST_EN | ST_ND);
    @(negedge clk) dreq[0] = 1'b1;
    idle(100);
    dreq[0] = 1'b0;
    bad = 0;
    for (int k = 0; k < 16; k++) if (mem['h200 + k] !== pat('h10 + k)) bad++;
    chk("R3", "word copy mismatching bytes", 32'(bad), 0);
    rd(ca(0, 'h08), v); chk("R5", "count after 4 units", v, 0);
    rd(ca(0, 'h10), v); chk("R6", "status done+ct", v, ST_EN | ST_ND | ST_DN | ST_CT);
    rd(ca(0, 'h00), v); chk("R4", "src stepped", v, 32'h20);
    rd(ca(0, 'h04), v); chk("R4", "dst stepped", v, 32'h210);
    rd(10'h304, v);     chk("R7", "summary bit0", v, 32'h1);
    chk("R7", "irq high", 32'(irq), 1);
    wr(ca(0, 'h10), ST_ND);
    rd(10'h304, v);     chk("R7", "summary cleared", v, 0);
    chk("R7", "irq low after ack", 32'(irq), 0);
  endtask

  // byte reads packed into a fixed word destination, no interrupt
  task automatic t_pack_fifo;
    logic [31:0] v;
    int b0;
    setup(1, 'h040, 'h300, 2, mkcmd(1, 0, 1, 0, 0, 0));
    b0 = beats;
    wr(ca(1, 'h10), ST_EN | ST_ND);
    @(negedge clk) dreq[1] = 1'b1;
    idle(100);
    dreq[1] = 1'b0;
    chk("R3", "beats for 2 byte-packed units", 32'(beats - b0), 10);
    v = {mem['h303], mem['h302], mem['h301], mem['h300]};
    chk("R3", "packed fifo word", v, {pat('h47), pat('h46), pat('h45), pat('h44)});
    rd(ca(1, 'h04), v); chk("R4", "fixed dst unchanged", v, 32'h300);
    rd(ca(1, 'h00), v); chk("R4", "byte src stepped", v, 32'h48);
    rd(ca(1, 'h10), v); chk("R6", "ch1 done", v & ST_DN, ST_DN);
    chk("R7", "irq low with interrupt disabled", 32'(irq), 0);
    wr(ca(1, 'h10), 32'd0);
  endtask

  // 16-byte units, halfword writes, one request pulse per unit
  task automatic t_single_req;
    logic [31:0] v;
    int b0, bad;
    setup(2, 'h080, 'h280, 2, mkcmd(1, 1, 0, 2, 3, 0));
    wr(ca(2, 'h10), ST_EN | ST_ND);
    b0 = beats;
    @(negedge clk) dreq[2] = 1'b1;
    @(negedge clk) dreq[2] = 1'b0;
    idle(80);
    chk("R10", "beats for one request", 32'(beats - b0), 12);
    rd(ca(2, 'h08), v); chk("R5", "live count mid transfer", v, 1);
    rd(ca(2, 'h04), v); chk("R4", "halfword dst stepped", v, 32'h290);
    @(negedge clk) dreq[2] = 1'b1;
    @(negedge clk) dreq[2] = 1'b0;
    idle(80);
    bad = 0;
    for (int k = 0; k < 32; k++) if (mem['h280 + k] !== pat('h80 + k)) bad++;
    chk("R3", "16-byte units mismatching bytes", 32'(bad), 0);
    rd(ca(2, 'h08), v); chk("R5", "count after second unit", v, 0);
    rd(ca(2, 'h10), v); chk("R6", "ch2 done", v & (ST_DN | ST_CT), ST_DN | ST_CT);
    b0 = beats;
    @(negedge clk) dreq[2] = 1'b1;
    idle(40);
    dreq[2] = 1'b0;
    chk("R6", "no beats after count zero", 32'(beats - b0), 0);
    wr(ca(2, 'h10), 32'd0);
  endtask

  task automatic gate_case(input string what, input logic [31:0] stc, input logic [31:0] g);
    logic [31:0] v;
    int b0;
    wr(10'h300, g);
    wr(ca(3, 'h10), stc);
    b0 = beats;
    @(negedge clk) dreq[3] = 1'b1;
    idle(30);
    dreq[3] = 1'b0;
    chk("R2", what, 32'(beats - b0), 0);
    rd(ca(3, 'h08), v); chk("R2", {what, " count kept"}, v, 1);
  endtask

  task automatic t_gating;
    logic [31:0] v;
    setup(3, 'h000, 'h380, 1, mkcmd(1, 1, 0, 0, 0, 0));
    gate_case("no armed bit", ST_EN, 32'h1);
    gate_case("no enable bit", ST_ND, 32'h1);
    gate_case("global enable off", ST_EN | ST_ND, 32'h0);
    gate_case("global halt", ST_EN | ST_ND, 32'h9);
    wr(10'h300, 32'h1);
    @(negedge clk) dreq[3] = 1'b1;
    idle(30);
    dreq[3] = 1'b0;
    rd(ca(3, 'h08), v); chk("R2", "runs when all gates open", v, 0);
    wr(ca(3, 'h10), 32'd0);
  endtask

  task automatic t_misalign;
    logic [31:0] v;
    int b0;
    setup(4, 'h102, 'h3C0, 1, mkcmd(1, 1, 0, 0, 0, 0));
    wr(ca(4, 'h10), ST_EN | ST_ND);
    b0 = beats;
    @(negedge clk) dreq[4] = 1'b1;
    idle(30);
    dreq[4] = 1'b0;
    chk("R8", "no beat at misaligned address", 32'(beats - b0), 0);
    rd(ca(4, 'h10), v); chk("R8", "ch4 status", v, ST_EN | ST_ND | ST_HLT | ST_AE);
    rd(ca(4, 'h08), v); chk("R8", "count unchanged", v, 1);
    rd(10'h300, v);     chk("R8", "global error bit", v, 32'h5);
    wr(10'h300, 32'h1);
    wr(ca(4, 'h10), 32'd0);
  endtask

  task automatic t_round_robin;
    logic [31:0] exp [6];
    int bad;
    exp[0] = 32'h000; exp[1] = 32'h0C0; exp[2] = 32'h004;
    exp[3] = 32'h0C4; exp[4] = 32'h008; exp[5] = 32'h0C8;
    setup(0, 'h000, 'h200, 3, mkcmd(1, 1, 0, 0, 0, 0));
    setup(1, 'h0C0, 'h240, 3, mkcmd(1, 1, 0, 0, 0, 0));
    wr(ca(0, 'h10), ST_EN | ST_ND);
    wr(ca(1, 'h10), ST_EN | ST_ND);
    @(negedge clk);
    nlog = 0;
    log_en = 1'b1;
    dreq[0] = 1'b1; dreq[1] = 1'b1;
    idle(100);
    dreq = '0;
    log_en = 1'b0;
    chk("R9", "interleaved read count", 32'(nlog), 6);
    bad = 0;
    for (int k = 0; k < 6; k++) if (rlog[k] !== exp[k]) bad++;
    chk("R9", "round-robin order mismatches", 32'(bad), 0);
  endtask

  initial begin
    finished = 1'b0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; beats = 0; nlog = 0; log_en = 1'b0;
    s_addr = '0; s_we = 1'b0; s_wdata = '0; dreq = '0; rst_n = 1'b0;
    for (int k = 0; k < MEMB; k++) mem[k] = (k < 256) ? pat(k) : 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    wr(10'h300, 32'h1);
    t_copy_words;
    t_pack_fifo;
    t_single_req;
    t_gating;
    t_misalign;
    t_round_robin;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule